// File: doc/BRIEF.md
# Sound Processor Peripheral Decoder

This block sits beside an 8-bit sound processor and holds every small peripheral that processor reaches through its memory map. It decodes the processor's address bus and its read and write strobes. The main processor drops a command byte into a latch and, with a separate strobe, raises an interrupt toward the sound processor. That interrupt stays asserted until the sound processor acknowledges it, and during the acknowledge the block drives the vector byte 0xFF.

The sound processor reads the command byte back, and it can read a free-running 4-bit timer that steps once per `TICK_DIV` processor clocks. It selects analog filter capacitors by writing anywhere in a small window: the filter register is loaded from the low address bits of that write, and the data bus is not used. To write a tone generator, the processor first places the byte in a staging register. It then writes one of four trigger addresses, and each trigger gives a one-cycle strobe to its own generator. The block also produces a clock enable at half the processor clock rate for the tone generators.

All interfaces are plain strobes. The main-side command write and every sound-side access complete in a single cycle, so the block applies no back-pressure.

Top module: `snd_periph_dec`

## Requirements
- R1: A synchronous active-high `rst` clears `snd_irq`, `filt_sel`, `tone_data`, `tone_strobe`, `tone_ce` and the timer to zero, and sets `snd_rdata` to 0xFF.
- R2: A cycle with `main_cmd_wr` high stores `main_cmd_data`. A later sound-side read of address 0x6000 returns that byte.
- R3: `main_irq_req` high sets `snd_irq` from the next cycle on. `snd_irq` then stays high until a cycle with `snd_iack` high and `main_irq_req` low, and it is low from the cycle after that one. If a request and an acknowledge fall in the same cycle, `snd_irq` stays high.
- R4: While `snd_iack` and `snd_irq` are both high, `snd_vector` is 0xFF. At all other times it is 0x00.
- R5: A command write while `snd_irq` is pending replaces the stored byte and leaves `snd_irq` high.
- R6: A read of 0x8000 returns the timer count in bits 3:0, with bits 7:4 at zero. The count steps by one every `TICK_DIV` (2048) clocks and wraps from 15 to 0, so two reads exactly 16*`TICK_DIV` clocks apart return the same value.
- R7: A sound-side write to any address in 0xA000–0xA1FF loads `filt_sel` from address bits 8:3, with `filt_sel[0]` taken from bit 3. Bits 1:0 feed generator 0, bits 3:2 optional generator 1, bit 4 generator 2 and bit 5 generator 3. The write data is ignored, and a write outside the window leaves `filt_sel` unchanged.
- R8: A sound-side write to 0xC000 loads `tone_data` with `snd_wdata`. The value holds until the next such write.
- R9: A write to 0xC001, 0xC002, 0xC003 or 0xC004 raises `tone_strobe` bit 0, 1, 2 or 3 respectively for exactly one cycle, starting the cycle after the write, while `tone_data` shows the staged byte. A write to 0xC005 raises no strobe and changes nothing else.
- R10: `snd_rdata` is loaded on the clock edge that samples `snd_rd` and holds its value when no read occurs. A read of an unmapped address, for example 0x1234 or 0x6001, returns 0xFF.
- R11: `tone_ce` is high on every second clock, giving the tone generators half the processor clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock (master clock / 4) |
| rst | input | 1 | Synchronous reset, active high |
| main_cmd_wr | input | 1 | Main-side strobe that stores a command byte |
| main_cmd_data | input | 8 | Command byte from the main processor |
| main_irq_req | input | 1 | Main-side strobe that raises the sound interrupt |
| snd_addr | input | 16 | Sound processor address bus |
| snd_rd | input | 1 | Sound processor read strobe |
| snd_wr | input | 1 | Sound processor write strobe |
| snd_wdata | input | 8 | Sound processor write data |
| snd_iack | input | 1 | Interrupt acknowledge from the sound processor |
| snd_rdata | output | 8 | Registered read data |
| snd_irq | output | 1 | Interrupt request to the sound processor |
| snd_vector | output | 8 | Vector byte driven during acknowledge |
| filt_sel | output | 6 | Filter capacitor select bits |
| tone_data | output | 8 | Staged byte for the tone generators |
| tone_strobe | output | 4 | One-cycle write strobes, one bit per generator |
| tone_ce | output | 1 | Tone generator clock enable (half rate) |

## Verification
Every registered result appears one edge after the stimulus that causes it. This covers read data, the interrupt level, the filter and staging registers, and the trigger strobes. The bench therefore applies inputs on the falling edge and checks on the following falling edge. The vector is combinational, so it is checked a moment after the acknowledge is applied, inside that same cycle. For the timer, the bench spaces two reads by an exact number of rising edges, `TICK_DIV` or 16*`TICK_DIV` apart. The difference between the two values is then fixed whatever the prescaler phase was.

// File: rtl/snd_periph_pkg.sv
package snd_periph_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_CMD,
    RG_TIMER,
    RG_FILT,
    RG_STAGE,
    RG_TRIG
  } snd_rgn_e;

  localparam logic [7:0] UNMAPPED_BYTE = 8'hFF;
endpackage

// File: rtl/snd_addr_decode.sv
module snd_addr_decode
  import snd_periph_pkg::*;
#(
  parameter int AW = 16,
  parameter int NGEN = 4,
  parameter logic [AW-1:0] CMD_ADDR = 16'h6000,
  parameter logic [AW-1:0] TMR_ADDR = 16'h8000,
  parameter logic [AW-1:0] FILT_BASE = 16'hA000,
  parameter int FILT_SPAN = 512,
  parameter logic [AW-1:0] STAGE_ADDR = 16'hC000
) (
  input  logic [AW-1:0]   addr,
  output snd_rgn_e        region,
  output logic [NGEN-1:0] trig_hot
);
  localparam int SPAN_W = $clog2(FILT_SPAN);

  logic in_filt;
  assign in_filt = (addr[AW-1:SPAN_W] == FILT_BASE[AW-1:SPAN_W]);

  // one compare per generator trigger address, following the staging address
  for (genvar g = 0; g < NGEN; g++) begin : g_trig
    assign trig_hot[g] = (addr == (STAGE_ADDR + AW'(g + 1)));
  end

  always_comb begin
    region = RG_NONE;
    if (addr == CMD_ADDR)        region = RG_CMD;
    else if (addr == TMR_ADDR)   region = RG_TIMER;
    else if (in_filt)            region = RG_FILT;
    else if (addr == STAGE_ADDR) region = RG_STAGE;
    else if (|trig_hot)          region = RG_TRIG;
  end
endmodule

// File: rtl/snd_cmd_latch.sv
module snd_cmd_latch #(
  parameter int DW = 8,
  parameter logic [DW-1:0] VEC = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_data,
  input  logic          irq_req,
  input  logic          iack,
  output logic [DW-1:0] cmd_q,
  output logic          irq,
  output logic [DW-1:0] vector
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= cmd_data;
      // a fresh request wins over an acknowledge in the same cycle
      if (irq_req)   irq <= 1'b1;
      else if (iack) irq <= 1'b0;
    end
  end

  assign vector = (iack && irq) ? VEC : '0;
endmodule

// File: rtl/snd_tick_timer.sv
module snd_tick_timer #(
  parameter int DIV = 2048,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] count,
  output logic          half_ce
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      count   <= '0;
      half_ce <= 1'b0;
    end else begin
      half_ce <= ~half_ce;
      if (pre == PRE_LAST) begin
        pre   <= '0;
        count <= count + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/snd_periph_dec.sv
module snd_periph_dec
  import snd_periph_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NGEN = 4,
  parameter int TICK_DIV = 2048,
  parameter int TMR_W = 4,
  parameter int FILT_LSB = 3,
  parameter int FILT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            main_cmd_wr,
  input  logic [DW-1:0]   main_cmd_data,
  input  logic            main_irq_req,
  input  logic [AW-1:0]   snd_addr,
  input  logic            snd_rd,
  input  logic            snd_wr,
  input  logic [DW-1:0]   snd_wdata,
  input  logic            snd_iack,
  output logic [DW-1:0]   snd_rdata,
  output logic            snd_irq,
  output logic [DW-1:0]   snd_vector,
  output logic [FILT_W-1:0] filt_sel,
  output logic [DW-1:0]   tone_data,
  output logic [NGEN-1:0] tone_strobe,
  output logic            tone_ce
);
  snd_rgn_e        region;
  logic [NGEN-1:0] trig_hot;
  logic [DW-1:0]   cmd_q;
  logic [TMR_W-1:0] tmr_count;
  logic [DW-1:0]   rd_next;

  snd_addr_decode #(.AW(AW), .NGEN(NGEN)) u_dec (
    .addr     (snd_addr),
    .region   (region),
    .trig_hot (trig_hot)
  );

  snd_cmd_latch #(.DW(DW)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (main_cmd_wr),
    .cmd_data (main_cmd_data),
    .irq_req  (main_irq_req),
    .iack     (snd_iack),
    .cmd_q    (cmd_q),
    .irq      (snd_irq),
    .vector   (snd_vector)
  );

  snd_tick_timer #(.DIV(TICK_DIV), .TW(TMR_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .count   (tmr_count),
    .half_ce (tone_ce)
  );

  always_comb begin
    rd_next = UNMAPPED_BYTE;
    case (region)
      RG_CMD:   rd_next = cmd_q;
      RG_TIMER: begin
        rd_next = '0;
        rd_next[TMR_W-1:0] = tmr_count;
      end
      default:  rd_next = UNMAPPED_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snd_rdata   <= UNMAPPED_BYTE;
      filt_sel    <= '0;
      tone_data   <= '0;
      tone_strobe <= '0;
    end else begin
      if (snd_rd) snd_rdata <= rd_next;
      if (snd_wr && region == RG_FILT)  filt_sel  <= snd_addr[FILT_LSB +: FILT_W];
      if (snd_wr && region == RG_STAGE) tone_data <= snd_wdata;
      tone_strobe <= (snd_wr && region == RG_TRIG) ? trig_hot : '0;
    end
  end
endmodule

// File: rtl/snd_periph_dec_chk.sv
module snd_periph_dec_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NGEN = 4,
  parameter int FILT_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            main_irq_req,
  input logic            snd_iack,
  input logic            snd_irq,
  input logic [DW-1:0]   snd_vector,
  input logic            snd_rd,
  input logic            snd_wr,
  input logic [AW-1:0]   snd_addr,
  input logic [DW-1:0]   snd_rdata,
  input logic [FILT_W-1:0] filt_sel,
  input logic [NGEN-1:0] tone_strobe,
  input logic            tone_ce
);
  logic filt_hit;
  assign filt_hit = snd_wr && (snd_addr[AW-1:9] == 7'b1010_000);

  p_irq_set_r3: assert property (@(posedge clk) disable iff (rst)
    main_irq_req |=> snd_irq);
  p_irq_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (snd_irq && !snd_iack) |=> snd_irq);
  p_irq_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (snd_irq && snd_iack && !main_irq_req) |=> !snd_irq);
  p_vector_r4: assert property (@(posedge clk) disable iff (rst)
    (snd_iack && snd_irq) |-> (snd_vector == 8'hFF));
  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tone_strobe));
  p_strobe_first_r9: assert property (@(posedge clk) disable iff (rst)
    (snd_wr && snd_addr == 16'hC001) |=> (tone_strobe == 4'b0001));
  p_filt_keep_r7: assert property (@(posedge clk) disable iff (rst)
    !filt_hit |=> $stable(filt_sel));
  p_rdata_keep_r10: assert property (@(posedge clk) disable iff (rst)
    !snd_rd |=> $stable(snd_rdata));
  p_ce_alt_r11: assert property (@(posedge clk) disable iff (rst)
    tone_ce |=> !tone_ce);
endmodule

bind snd_periph_dec snd_periph_dec_chk #(.AW(AW), .DW(DW), .NGEN(NGEN), .FILT_W(FILT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .main_irq_req (main_irq_req),
  .snd_iack     (snd_iack),
  .snd_irq      (snd_irq),
  .snd_vector   (snd_vector),
  .snd_rd       (snd_rd),
  .snd_wr       (snd_wr),
  .snd_addr     (snd_addr),
  .snd_rdata    (snd_rdata),
  .filt_sel     (filt_sel),
  .tone_strobe  (tone_strobe),
  .tone_ce      (tone_ce)
);

// File: tb/snd_periph_dec_test.sv
`timescale 1ns/1ps
module snd_periph_dec_test;
  localparam int TICK = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_cmd_wr = 1'b0, main_irq_req = 1'b0;
  logic [7:0] main_cmd_data = '0;
  logic [15:0] snd_addr = '0;
  logic snd_rd = 1'b0, snd_wr = 1'b0, snd_iack = 1'b0;
  logic [7:0] snd_wdata = '0;
  logic [7:0] snd_rdata, snd_vector, tone_data;
  logic snd_irq, tone_ce;
  logic [5:0] filt_sel;
  logic [3:0] tone_strobe;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  snd_periph_dec uut (
    .clk(clk), .rst(rst),
    .main_cmd_wr(main_cmd_wr), .main_cmd_data(main_cmd_data), .main_irq_req(main_irq_req),
    .snd_addr(snd_addr), .snd_rd(snd_rd), .snd_wr(snd_wr), .snd_wdata(snd_wdata),
    .snd_iack(snd_iack), .snd_rdata(snd_rdata), .snd_irq(snd_irq), .snd_vector(snd_vector),
    .filt_sel(filt_sel), .tone_data(tone_data), .tone_strobe(tone_strobe), .tone_ce(tone_ce)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sread(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); snd_addr = a; snd_rd = 1'b1;
    @(negedge clk); snd_rd = 1'b0; d = snd_rdata;
  endtask

  task automatic swrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); snd_addr = a; snd_wdata = d; snd_wr = 1'b1;
    @(negedge clk); snd_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 irq", snd_irq, 0);
    check("R1 filt", filt_sel, 0);
    check("R1 tone_data", tone_data, 0);
    check("R1 strobe", tone_strobe, 0);
    check("R1 rdata", snd_rdata, 8'hFF);
    check("R1 ce", tone_ce, 0);
  endtask

  task automatic t_command();
    logic [7:0] d;
    @(negedge clk); main_cmd_data = 8'h5A; main_cmd_wr = 1'b1;
    @(negedge clk); main_cmd_wr = 1'b0;
    sread(16'h6000, d);
    check("R2 cmd read", d, 8'h5A);
    check("R3 no irq from data write", snd_irq, 0);
  endtask

  task automatic t_irq();
    @(negedge clk); main_irq_req = 1'b1;
    @(negedge clk); main_irq_req = 1'b0;
    check("R3 irq set", snd_irq, 1);
    repeat (3) @(negedge clk);
    check("R3 irq held", snd_irq, 1);
    check("R4 vector idle", snd_vector, 0);
    // R5: new command while pending
    main_cmd_data = 8'hC3; main_cmd_wr = 1'b1;
    @(negedge clk); main_cmd_wr = 1'b0;
    check("R5 irq kept", snd_irq, 1);
    snd_iack = 1'b1; #1;
    check("R4 vector during ack", snd_vector, 8'hFF);
    @(negedge clk); snd_iack = 1'b0;
    check("R3 irq cleared", snd_irq, 0);
    begin
      logic [7:0] d;
      sread(16'h6000, d);
      check("R5 cmd replaced", d, 8'hC3);
    end
    // R3: request and ack together
    @(negedge clk); main_irq_req = 1'b1;
    @(negedge clk); snd_iack = 1'b1;
    @(negedge clk); main_irq_req = 1'b0; snd_iack = 1'b0;
    check("R3 req beats ack", snd_irq, 1);
    @(negedge clk); snd_iack = 1'b1;
    @(negedge clk); snd_iack = 1'b0;
    check("R3 irq cleared again", snd_irq, 0);
  endtask

  task automatic t_filter();
    swrite(16'hA000 | (16'h1 << 3) | (16'h1 << 6) | (16'h1 << 8), 8'h00);
    check("R7 filt bits", filt_sel, 6'b101001);
    swrite(16'hA1F8, 8'h00);
    check("R7 filt all", filt_sel, 6'b111111);
    swrite(16'hA010, 8'hFF);
    check("R7 data ignored", filt_sel, 6'b000010);
    swrite(16'hA208, 8'h00);
    check("R7 outside window", filt_sel, 6'b000010);
  endtask

  task automatic t_tone();
    swrite(16'hC000, 8'h9E);
    check("R8 staged", tone_data, 8'h9E);
    for (int g = 0; g < 4; g++) begin
      @(negedge clk); snd_addr = 16'hC001 + 16'(g); snd_wr = 1'b1;
      @(negedge clk); snd_wr = 1'b0;
      check("R9 strobe", tone_strobe, 32'(1) << g);
      check("R9 data with strobe", tone_data, 8'h9E);
      @(negedge clk);
      check("R9 strobe one cycle", tone_strobe, 0);
    end
    @(negedge clk); snd_addr = 16'hC005; snd_wdata = 8'h11; snd_wr = 1'b1;
    @(negedge clk); snd_wr = 1'b0;
    check("R9 C005 no strobe", tone_strobe, 0);
    check("R9 C005 data kept", tone_data, 8'h9E);
  endtask

  task automatic t_reads();
    logic [7:0] d;
    sread(16'h1234, d);
    check("R10 unmapped", d, 8'hFF);
    sread(16'h6001, d);
    check("R10 unmapped near cmd", d, 8'hFF);
    repeat (3) @(negedge clk);
    check("R10 hold", snd_rdata, 8'hFF);
  endtask

  task automatic t_timer();
    logic [7:0] a, b, c;
    sread(16'h8000, a);
    check("R6 zero after reset", a, 0);
    repeat (TICK - 2) @(negedge clk);
    sread(16'h8000, b);
    check("R6 step", b, 32'((a + 1) & 8'h0F));
    repeat (16 * TICK - 2) @(negedge clk);
    sread(16'h8000, c);
    check("R6 wrap", c, b);
  endtask

  task automatic t_ce();
    logic x, y;
    @(negedge clk); x = tone_ce;
    @(negedge clk); y = tone_ce;
    check("R11 alternate", {x, y} == 2'b01 || {x, y} == 2'b10, 1);
  endtask

  task automatic t_reset_again();
    @(negedge clk); main_irq_req = 1'b1;
    @(negedge clk); main_irq_req = 1'b0;
    swrite(16'hA1F8, 8'h00);
    do_reset();
    t_reset_state();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_timer();
    t_command();
    t_irq();
    t_filter();
    t_tone();
    t_reads();
    t_ce();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule